// File: doc/BRIEF.md
# PWM Counter Event Interrupt and ADC Trigger Generator

This block sits beside a PWM generator's counter and turns selected counter events into two outputs: a level interrupt request and a one-clock ADC trigger pulse. It compares the counter value against zero, the load value and two compare values, A and B. It qualifies each compare match by the counting direction, which gives six distinct events. Each event has its own enable on the interrupt path and its own enable on the trigger path.

Software reaches the block through a small register port. One address holds the enable register. A second address holds an interrupt status register whose bits are cleared by writing a one. The trigger path merges every enabled event into a single pulse and keeps no record of which event fired. The interrupt path latches each enabled event in its own status bit.

Top module: `pwm_evt_gen`

## Requirements
- R1: After a synchronous reset the enable register reads 0, the status register reads 0, and both `irq_o` and `adc_trig_o` are 0.
- R2: Address 0 is the enable register and address 1 is the status register. Other addresses read 0 and ignore writes. Interrupt enables sit in bits 5:0 and trigger enables in bits 13:8. Both fields use the same event order: bit 0 is counter equals zero, bit 1 is counter equals load, bit 2 is compare A while counting up, bit 3 is compare A while counting down, bit 4 is compare B while counting up, and bit 5 is compare B while counting down.
- R3: Bits 31:14 and 7:6 of the enable register, and bits 31:6 of the status register, ignore writes and read back as 0.
- R4: The zero event fires when `cnt_val` is 0. The load event fires when `cnt_val` equals `load_val`. Neither depends on direction.
- R5: A compare event fires only while `cnt_up` matches the direction of that event. `cnt_up`=1 means counting up. While `cnt_up`=0, the up-qualified events never fire.
- R6: An event fires only on the first cycle its condition becomes true. The resulting trigger is high for exactly one clock, in the cycle after the inputs are sampled, even if the counter holds its value.
- R7: `adc_trig_o` is the OR of every event whose trigger enable is 1, for any combination of enables. Events whose trigger enable is 0 produce no pulse.
- R8: A status bit sets when its event fires while its interrupt enable is 1. An event whose interrupt enable is 0 leaves the status bit unchanged.
- R9: Writing 1 to a status bit clears it. Writing 0 to a status bit leaves it unchanged.
- R10: When an enabled event fires in the same cycle as a write that clears its status bit, the bit stays set.
- R11: `irq_o` is the OR of the status bits. It follows the status register with no extra delay, so it rises in the cycle after an enabled event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | CNT_W | Current counter value |
| cnt_up | input | 1 | 1 while counting up, 0 while counting down |
| load_val | input | CNT_W | Counter load value |
| cmp_a | input | CNT_W | Compare value A |
| cmp_b | input | CNT_W | Compare value B |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from the address |
| irq_o | output | 1 | Level interrupt request |
| adc_trig_o | output | 1 | One-clock ADC trigger pulse |

## Verification
Two functions can act in the same clock cycle: a counter event that sets a status bit, and a software write that clears the same bit. The bench provokes this by stepping the counter onto compare A while counting down, in the same cycle as a write of that bit to the status address. It then judges the outcome from the status readback and from `irq_o`, both of which must remain set. Every cycle, a scoreboard also compares the trigger pulse and the interrupt level against a model built from the requirements. This covers a counter held on a match and a direction change while the counter is held on a compare value.

// File: rtl/pwm_evt_pkg.sv
package pwm_evt_pkg;

    localparam int NUM_EVT = 6;
    localparam int REG_W   = 32;
    localparam int TRG_LSB = 8;
    localparam int ADDR_W  = 2;

    localparam logic [ADDR_W-1:0] ADR_ENABLE = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADR_STATUS = ADDR_W'(1);

    // event index inside every event vector; the enable and status fields use this order
    typedef enum logic [2:0] {
        EV_ZERO = 3'd0,
        EV_LOAD = 3'd1,
        EV_A_UP = 3'd2,
        EV_A_DN = 3'd3,
        EV_B_UP = 3'd4,
        EV_B_DN = 3'd5
    } evt_id_e;

    typedef logic [NUM_EVT-1:0] evt_vec_t;

    typedef struct packed {
        evt_vec_t trg;
        evt_vec_t irq;
    } en_cfg_t;

    function automatic logic [REG_W-1:0] pack_en(input en_cfg_t c);
        logic [REG_W-1:0] r;
        r = '0;
        r[TRG_LSB +: NUM_EVT] = c.trg;
        r[NUM_EVT-1:0]        = c.irq;
        return r;
    endfunction

    function automatic en_cfg_t unpack_en(input logic [REG_W-1:0] w);
        en_cfg_t c;
        c.trg = w[TRG_LSB +: NUM_EVT];
        c.irq = w[NUM_EVT-1:0];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_sts(input evt_vec_t s);
        logic [REG_W-1:0] r;
        r = '0;
        r[NUM_EVT-1:0] = s;
        return r;
    endfunction

endpackage

// File: rtl/pwm_evt_detect.sv
module pwm_evt_detect
    import pwm_evt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_up,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    output evt_vec_t         evt_rise
);

    localparam int NUM_CMP = 2;

    logic [NUM_CMP-1:0] cmp_hit;
    evt_vec_t           match_lvl;
    evt_vec_t           match_prev;

    // compare channels A and B, each split by direction
    generate
        for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
            logic [CNT_W-1:0] ref_val;
            assign ref_val    = (g == 0) ? cmp_a : cmp_b;
            assign cmp_hit[g] = (cnt_val == ref_val);
            assign match_lvl[2 + 2*g] = cmp_hit[g] &  cnt_up;
            assign match_lvl[3 + 2*g] = cmp_hit[g] & ~cnt_up;
        end
    endgenerate

    assign match_lvl[EV_ZERO] = (cnt_val == '0);
    assign match_lvl[EV_LOAD] = (cnt_val == load_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            match_prev <= '0;
        end else begin
            match_prev <= match_lvl;
        end
    end

    assign evt_rise = match_lvl & ~match_prev;

endmodule

// File: rtl/pwm_evt_regs.sv
module pwm_evt_regs
    import pwm_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  evt_vec_t          evt,
    output en_cfg_t           cfg_q,
    output evt_vec_t          sts_q,
    output logic [REG_W-1:0]  reg_rdata
);

    logic     wr_en;
    logic     wr_sts;
    evt_vec_t clr_mask;
    evt_vec_t set_mask;

    assign wr_en    = reg_wr && (reg_addr == ADR_ENABLE);
    assign wr_sts   = reg_wr && (reg_addr == ADR_STATUS);
    assign clr_mask = wr_sts ? unpack_en(reg_wdata).irq : '0;
    assign set_mask = evt & cfg_q.irq;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q <= unpack_en(reg_wdata);
        end
    end

    // a new event takes priority over a clear of the same bit
    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= '0;
        end else begin
            sts_q <= (sts_q & ~clr_mask) | set_mask;
        end
    end

    always_comb begin
        case (reg_addr)
            ADR_ENABLE: reg_rdata = pack_en(cfg_q);
            ADR_STATUS: reg_rdata = pack_sts(sts_q);
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pwm_evt_trig.sv
module pwm_evt_trig
    import pwm_evt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  evt_vec_t evt,
    input  evt_vec_t trg_en,
    output logic     adc_trig
);

    always_ff @(posedge clk) begin
        if (rst) begin
            adc_trig <= 1'b0;
        end else begin
            adc_trig <= |(evt & trg_en);
        end
    end

endmodule

// File: rtl/pwm_evt_gen.sv
module pwm_evt_gen
    import pwm_evt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              cnt_up,
    input  logic [CNT_W-1:0]  load_val,
    input  logic [CNT_W-1:0]  cmp_a,
    input  logic [CNT_W-1:0]  cmp_b,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq_o,
    output logic              adc_trig_o
);

    evt_vec_t evt_rise;
    en_cfg_t  en_cfg;
    evt_vec_t sts_q;

    pwm_evt_detect #(.CNT_W(CNT_W)) u_detect (
        .clk      (clk),
        .rst      (rst),
        .cnt_val  (cnt_val),
        .cnt_up   (cnt_up),
        .load_val (load_val),
        .cmp_a    (cmp_a),
        .cmp_b    (cmp_b),
        .evt_rise (evt_rise)
    );

    pwm_evt_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .evt       (evt_rise),
        .cfg_q     (en_cfg),
        .sts_q     (sts_q),
        .reg_rdata (reg_rdata)
    );

    pwm_evt_trig u_trig (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_rise),
        .trg_en   (en_cfg.trg),
        .adc_trig (adc_trig_o)
    );

    assign irq_o = |sts_q;

endmodule

// File: rtl/pwm_evt_chk.sv
module pwm_evt_chk
    import pwm_evt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [CNT_W-1:0]  cnt_val,
    input logic              cnt_up,
    input logic [CNT_W-1:0]  load_val,
    input logic [CNT_W-1:0]  cmp_a,
    input logic [CNT_W-1:0]  cmp_b,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [REG_W-1:0]  reg_rdata,
    input logic              irq_o,
    input logic              adc_trig_o,
    input evt_vec_t          evt,
    input en_cfg_t           cfg,
    input evt_vec_t          sts
);

    logic sts_wr;
    assign sts_wr = reg_wr && (reg_addr == ADR_STATUS);

    AST_RST_CLEAN: assert property (@(posedge clk)
        $past(rst) && !rst |-> (!adc_trig_o && !irq_o && sts == '0));  // R1

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[REG_W-1:TRG_LSB+NUM_EVT] == '0) && (reg_rdata[TRG_LSB-1:NUM_EVT] == '0));  // R3

    AST_DOWN_NO_UP: assert property (@(posedge clk) disable iff (rst)
        !cnt_up |-> !(evt[EV_A_UP] || evt[EV_B_UP]));  // R5

    AST_HOLD_NO_TRIG: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(cnt_val) && $stable(cnt_up) && $stable(load_val)
         && $stable(cmp_a) && $stable(cmp_b)) |=> !adc_trig_o);  // R6

    AST_TRIG_ENABLED: assert property (@(posedge clk) disable iff (rst)
        adc_trig_o |-> $past(cfg.trg != '0));  // R7

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !sts_wr) |=> irq_o);  // R11

    generate
        for (genvar k = 0; k < NUM_EVT; k++) begin : g_set
            AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
                (sts_wr && reg_wdata[k] && evt[k] && cfg.irq[k]) |=> sts[k]);  // R10
        end
    endgenerate

endmodule

bind pwm_evt_gen pwm_evt_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cnt_val    (cnt_val),
    .cnt_up     (cnt_up),
    .load_val   (load_val),
    .cmp_a      (cmp_a),
    .cmp_b      (cmp_b),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .irq_o      (irq_o),
    .adc_trig_o (adc_trig_o),
    .evt        (evt_rise),
    .cfg        (en_cfg),
    .sts        (sts_q)
);

// File: tb/tb_pwm_evt_gen.sv
module tb_pwm_evt_gen;
    import pwm_evt_pkg::*;

    localparam int CNT_W = 16;
    localparam int LOADV = 20;
    localparam int CMPA  = 7;
    localparam int CMPB  = 13;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [CNT_W-1:0]  cnt_val = '0;
    logic              cnt_up = 1'b1;
    logic [CNT_W-1:0]  load_val = CNT_W'(LOADV);
    logic [CNT_W-1:0]  cmp_a = CNT_W'(CMPA);
    logic [CNT_W-1:0]  cmp_b = CNT_W'(CMPB);
    logic              reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [REG_W-1:0]  reg_wdata = '0;
    logic [REG_W-1:0]  reg_rdata;
    logic              irq_o;
    logic              adc_trig_o;

    always #4 clk = ~clk;

    pwm_evt_gen #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .cnt_val(cnt_val), .cnt_up(cnt_up),
        .load_val(load_val), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o), .adc_trig_o(adc_trig_o)
    );

    typedef struct {
        bit    trig;
        bit    irq;
        string tag;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;

    // reference state, built from the requirements
    bit [5:0] m_prev = '0;
    bit [5:0] m_int  = '0;
    bit [5:0] m_trg  = '0;
    bit [5:0] m_sts  = '0;

    task automatic check(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int c, input bit up, input bit wr, input int a,
                        input logic [31:0] wd, input string tag);
        bit [5:0] lvl, ev, clr;
        exp_t e;
        @(negedge clk);
        cnt_val   = CNT_W'(c);
        cnt_up    = up;
        reg_wr    = wr;
        reg_addr  = ADDR_W'(a);
        reg_wdata = wd;
        lvl[0] = (c == 0);
        lvl[1] = (c == LOADV);
        lvl[2] = (c == CMPA) && up;
        lvl[3] = (c == CMPA) && !up;
        lvl[4] = (c == CMPB) && up;
        lvl[5] = (c == CMPB) && !up;
        ev     = lvl & ~m_prev;
        m_prev = lvl;
        e.trig = |(ev & m_trg);
        clr    = (wr && a == 1) ? wd[5:0] : 6'd0;
        m_sts  = (m_sts & ~clr) | (ev & m_int);
        if (wr && a == 0) begin
            m_int = wd[5:0];
            m_trg = wd[13:8];
        end
        e.irq = (m_sts != 0);
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic rd_chk(input int a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_wr   = 1'b0;
        reg_addr = ADDR_W'(a);
        #1;
        check(tag, reg_rdata, exp);
    endtask

    // scoreboard monitor: one expected item per driven cycle
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check({e.tag, " trig"}, adc_trig_o, e.trig);
            check({e.tag, " irq"}, irq_o, e.irq);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 trig", adc_trig_o, 0);
        check("R1 irq", irq_o, 0);
        rd_chk(0, 32'h0, "R1 enable");
        rd_chk(1, 32'h0, "R1 status");

        // R3: reserved bits ignore writes
        step(5, 1, 1, 0, 32'hFFFF_FFFF, "R3");
        rd_chk(0, 32'h0000_3F3F, "R3 enable readback");
        step(5, 1, 1, 0, 32'h0, "R2");
        step(5, 1, 1, 1, 32'hFFFF_FFFF, "R3");
        rd_chk(1, 32'h0, "R3 status readback");
        rd_chk(2, 32'h0, "R2 unmapped");
        step(5, 1, 1, 2, 32'hFFFF_FFFF, "R2");
        rd_chk(0, 32'h0, "R2 unmapped write");

        // R4 R5 R7: all trigger enables, up then down sweep
        step(5, 1, 1, 0, 32'h0000_3F00, "R7");
        rd_chk(0, 32'h0000_3F00, "R2 trigger field");
        for (int i = 0; i <= LOADV; i++) step(i, 1, 0, 0, 0, "R4");
        for (int i = LOADV - 1; i >= 0; i--) step(i, 0, 0, 0, 0, "R5");

        // R6: counter held on a compare value
        step(3, 1, 0, 0, 0, "R6");
        for (int i = 0; i < 4; i++) step(CMPA, 1, 0, 0, 0, "R6");
        step(CMPA, 0, 0, 0, 0, "R5");
        step(CMPA, 0, 0, 0, 0, "R6");

        // R7: subset of triggers (zero and B-down)
        step(9, 1, 1, 0, 32'h0000_2100, "R7");
        for (int i = 0; i <= LOADV; i++) step(i, 1, 0, 0, 0, "R7");
        for (int i = LOADV - 1; i >= 0; i--) step(i, 0, 0, 0, 0, "R7");

        // R8 R11: interrupt on compare A down only
        step(10, 0, 1, 0, 32'h0000_0008, "R8");
        for (int i = 10; i >= 5; i--) step(i, 0, 0, 0, 0, "R11");
        rd_chk(1, 32'h0000_0008, "R8 status");
        step(5, 0, 1, 1, 32'h0000_0000, "R9");
        rd_chk(1, 32'h0000_0008, "R9 write zero");
        step(5, 0, 1, 1, 32'h0000_0008, "R9");
        rd_chk(1, 32'h0, "R9 cleared");

        // R8: disabled event (zero) leaves status alone
        for (int i = 4; i >= 0; i--) step(i, 0, 0, 0, 0, "R8");
        rd_chk(1, 32'h0, "R8 disabled event");

        // R10: set and clear in the same cycle
        step(CMPA + 1, 0, 0, 0, 0, "R10");
        step(CMPA, 0, 1, 1, 32'h0000_0008, "R10");
        rd_chk(1, 32'h0000_0008, "R10 status kept");
        step(CMPA, 0, 0, 0, 0, "R10");
        step(CMPA, 0, 1, 1, 32'h0000_0008, "R9");
        step(CMPA, 0, 0, 0, 0, "R11");

        repeat (3) @(posedge clk);
        #3;
        check("scoreboard drained", q.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule